// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands one multiplier bit per clock cycle. The multiplicand is kept in a register that does not change during an operation. The multiplier is loaded into the low half of a double-width accumulator, and the upper half starts at zero. On each step the accumulator's least significant bit is examined. When that bit is 1, a single operand-width adder adds the multiplicand into the upper half. The whole accumulator, with the adder's carry as an extra top bit, then shifts right by one place.

The block is used as a slow, small arithmetic unit beside a datapath. The user pulses `start_i` while the block is idle and later reads `prod_o` when `done_o` pulses. A start pulse that arrives during an operation is ignored. The finished product stays on `prod_o` until the next accepted start.

Top module: `seq_mult`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `prod_o` is all zeros.
- R2: A `start_i` sampled high on a rising edge while `busy_o` is 0 is accepted. `busy_o` is 1 from that edge onward.
- R3: When `done_o` is 1, `prod_o` equals the full unsigned product of the operands captured at the accepting edge, zero-extended to 2·WIDTH bits.
- R4: An operation takes exactly WIDTH steps. `done_o` rises WIDTH clock edges after the accepting edge, and at that same edge `busy_o` falls.
- R5: `done_o` is a single-cycle pulse and is never 1 together with `busy_o`.
- R6: A `start_i` pulse while `busy_o` is 1 has no effect. The running operation's result and timing are unchanged, and no extra `done_o` pulse occurs.
- R7: The multiplicand register stays constant for the whole operation.
- R8: The adder's carry-out is kept through the shift, so all-ones times all-ones gives the exact product (for WIDTH=32, 0xFFFFFFFE00000001).
- R9: Changes on `mcand_i` or `mplier_i` after the accepting edge do not affect the result.
- R10: While idle and without an accepted start, `prod_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 2·WIDTH | Accumulator; holds the product after completion |

## Verification
Several properties are checked on every cycle by assertions:
- `done_o` always accompanies the fall of `busy_o`, lasts one cycle and never overlaps busy.
- The step counter stays in range.
- A start is never accepted mid-run.
- The multiplicand register is frozen while steps run.
- The product register holds while idle.

Other behaviours can only be shown by the bench's scenarios. These are the arithmetic correctness of the product, including the carry boundary at all-ones operands, and the exact WIDTH-cycle latency. They also include the independence of the result from operand changes and from ignored start pulses, because these need a reference product computed separately.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sm_state_e;
endpackage

// File: rtl/seq_mult_ctrl.sv
module seq_mult_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import seq_mult_pkg::*;

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  sm_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic        done_q;
  logic        last_step;

  assign load_o    = start_i && (state_q == ST_IDLE);
  assign step_o    = (state_q == ST_RUN);
  assign last_step = step_o && (cnt_q == LAST);
  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_step) state_q <= ST_IDLE;
      end
    end
  end

  // R4: the step counter never passes the final step
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6: a start is only accepted outside a run
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && start_i) |=> (cnt_q != '0) || !busy_o);
endmodule

// File: rtl/seq_mult_dp.sv
module seq_mult_dp #(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic [WIDTH-1:0]     mcand_i,
  input  logic [WIDTH-1:0]     mplier_i,
  output logic [2*WIDTH-1:0]   prod_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    acc_q;
  logic [PW-1:0]    acc_next;
  logic             add_en;

  // one add-then-shift step; the carry lands in the top bit after the shift
  function automatic logic [PW-1:0] add_shift(input logic [PW-1:0] acc,
                                               input logic [WIDTH-1:0] mc);
    logic [WIDTH:0] sum;
    sum = {1'b0, acc[PW-1:WIDTH]} + (acc[0] ? {1'b0, mc} : '0);
    return {sum, acc[WIDTH-1:1]};
  endfunction

  assign add_en   = step_i && acc_q[0];
  assign acc_next = add_shift(acc_q, mcand_q);
  assign prod_o   = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      acc_q   <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      acc_q <= acc_next;
    end
  end

  // R7: multiplicand frozen across steps
  p_mcand_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(mcand_q));
  // R8: a step without an add leaves the top bit clear
  p_no_add_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !add_en) |=> !acc_q[PW-1]);
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] prod_o
);
  logic load_w;
  logic step_w;

  seq_mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load_w), .step_o(step_w), .busy_o(busy_o), .done_o(done_o)
  );

  seq_mult_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
    .mcand_i(mcand_i), .mplier_i(mplier_i), .prod_o(prod_o)
  );

  // R4: completion coincides with the end of busy
  p_done_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R5: single-cycle pulse, never during busy
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  // R2: an idle start makes the block busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R10: idle without start holds the product
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

// File: tb/sim_seq_mult.sv
module sim_seq_mult;
  localparam int W = 32;
  localparam int LIMIT = 100000;

  typedef struct packed {
    logic [2*W-1:0] prod;
    logic [31:0]    cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic busy_o, done_o;
  logic [2*W-1:0] prod_o;

  int total = 0;
  int bad = 0;
  logic [31:0] cyc = 0;
  logic finished = 1'b0;
  logic done_prev = 1'b0;
  exp_t sb[$];

  seq_mult #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req,
                     input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: waits for idle, pulses start, pushes the expected item
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    while (busy_o) @(negedge clk);
    mcand_i = a;
    mplier_i = b;
    start_i = 1'b1;
    e.prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    e.cyc = cyc + 1 + W;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", {63'b0, busy_o}, 64'd1);
    // R9: scramble the operand inputs after capture
    mcand_i = ~a;
    mplier_i = b ^ 32'h5A5A_A5A5;
  endtask

  // monitor: pops and compares on each completion
  always @(negedge clk) begin
    if (!finished && cyc > LIMIT) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      finish_run();
    end
    if (rst_n) begin
      if (done_o) begin
        chk(!done_prev, "R5 done pulse width", {63'b0, done_prev}, 64'd0);
        chk(!busy_o, "R5 done without busy", {63'b0, busy_o}, 64'd0);
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(prod_o === e.prod, "R3 product", prod_o, e.prod);
          chk(cyc === e.cyc, "R4 latency", {32'b0, cyc}, {32'b0, e.cyc});
        end
      end
      done_prev <= done_o;
    end
  end

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0, "R1 busy reset", {63'b0, busy_o}, 64'd0);
    chk(done_o === 1'b0, "R1 done reset", {63'b0, done_o}, 64'd0);
    chk(prod_o === '0, "R1 prod reset", prod_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(32'd6, 32'd5);                 // R3 small case, 30
    issue(32'd0, 32'h1234_5678);         // R3 zero multiplicand
    issue(32'hDEAD_BEEF, 32'd0);         // R3 zero multiplier
    issue(32'd1, 32'hCAFE_F00D);         // R3 unit multiplicand
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF); // R8 carry boundary
    issue(32'hFFFF_FFFF, 32'd1);         // R8 single add with carry-free top
    issue(32'h8000_0000, 32'd2);         // R3 top bit multiplicand

    // R6: start pulses during a run are ignored
    issue(32'd1000, 32'd77);
    repeat (5) @(negedge clk);
    mcand_i = 32'hFFFF_0000;
    mplier_i = 32'h0000_FFFF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;

    // R10: product holds while idle
    while (busy_o || done_o) @(negedge clk);
    held = prod_o;
    chk(held === 64'd77000, "R6 result after ignored start", held, 64'd77000);
    repeat (6) @(negedge clk);
    chk(prod_o === held, "R10 hold while idle", prod_o, held);

    for (int i = 0; i < 20; i++) issue($urandom, $urandom);

    while (busy_o || sb.size() != 0) @(negedge clk);
    repeat (W + 4) @(negedge clk);
    chk(sb.size() == 0, "R6 scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule